// File: doc/BRIEF.md
# Co-tagged Translation Buffer with Snoop Invalidation

This block is a small, fully associative translation buffer. Every entry pairs a virtual page number with a physical frame number. It also keeps a co-tag: the system physical address of the page-table entry that produced the mapping. A core uses the lookup port to translate a page and the fill port to install a translation after a walk. The coherence side uses the snoop port.

When a page is remapped, the remapping agent sends the system physical address of the changed mapping on the snoop port. The buffer compares that address with the co-tag of every valid entry. It drops only the entries that match, so other translations survive and nothing is flushed. It then acknowledges the request in hardware. A snoop that matches nothing is still acknowledged. Lookups keep running while snoops are served.

Top module: `cotag_tlb`

## Requirements
- R1: After the synchronous active-high reset, no entry is valid, `snoop_ready` is 1, and `snoop_ack`, `look_hit` and `look_miss` are 0. The first lookup after reset reports a miss.
- R2: A lookup offered with `look_valid` is answered in the next cycle. The answer is exactly one of `look_hit` (with `look_pfn` holding the frame) or `look_miss`. Both are 0 in any cycle that follows a cycle without a lookup.
- R3: A fill installs the page number, frame and co-tag, and lookups in later cycles hit on it. A lookup in the same cycle as the fill still sees the old contents.
- R4: A fill whose page number is already held overwrites that entry, including its co-tag. No second copy of the page number is created.
- R5: A fill of a new page number uses the lowest-numbered invalid entry if there is one. Otherwise it replaces the least recently used entry, where both a lookup hit and a fill count as a use.
- R6: An accepted snoop invalidates every valid entry whose co-tag equals `snoop_spa`, and only those entries.
- R7: An accepted snoop that matches no co-tag is still acknowledged, and every entry stays as it was.
- R8: `snoop_ack` is 1 for exactly one cycle, the cycle after a snoop is accepted (`snoop_valid` and `snoop_ready` both 1). `snoop_ready` is 0 during that cycle, so a snoop held high is accepted only every second cycle.
- R9: A lookup and a snoop in the same cycle are both served. If the snoop removes the looked-up entry, the lookup reports a miss.
- R10: A fill and a snoop in the same cycle are both applied. The filled entry is valid afterwards even if its new co-tag matches the snoop address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| look_valid | input | 1 | Lookup request |
| look_vpn | input | VPN_W | Virtual page number to translate |
| look_hit | output | 1 | Registered hit for the previous cycle's lookup |
| look_miss | output | 1 | Registered miss for the previous cycle's lookup |
| look_pfn | output | PFN_W | Frame number on a hit, 0 otherwise |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_cotag | input | SPA_W | System physical address co-tag to install |
| snoop_valid | input | 1 | Invalidation request |
| snoop_spa | input | SPA_W | System physical address to match against co-tags |
| snoop_ready | output | 1 | Snoop can be accepted this cycle |
| snoop_ack | output | 1 | One-cycle acknowledgement of an accepted snoop |

## Verification
The bench builds the buffer with eight entries and narrow 12-bit page, 12-bit frame and 16-bit address fields. With eight entries, a full buffer and then two successive evictions take only a few fills, so the replacement order can be checked step by step. Pairs of entries share a co-tag, so one snoop that removes several entries while their neighbours survive can be seen on the lookup port. The same-cycle combinations of lookup with fill, lookup with snoop, and fill with snoop are each driven in a single cycle.

// File: rtl/cotag_tlb_pkg.sv
package cotag_tlb_pkg;

  // where a fill lands
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,   // page already present: overwrite in place
    SLOT_FREE  = 2'd1,   // lowest invalid entry
    SLOT_EVICT = 2'd2    // least recently used entry
  } slot_src_e;

endpackage

// File: rtl/cotag_tlb_cam.sv
module cotag_tlb_cam #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SPA_W = 28,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [SPA_W-1:0] snoop_spa,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [SPA_W-1:0] wr_cotag,
  input  logic             inv_en,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     look_match,
  output logic [N-1:0]     fill_match,
  output logic [N-1:0]     snoop_match,
  output logic [PFN_W-1:0] look_pfn_any
);

  logic [VPN_W-1:0] vpn_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  logic [SPA_W-1:0] tag_q [N];
  logic [N-1:0]     valid_q;

  assign valid_vec = valid_q;

  // payload arrays: no reset, qualified by valid_q
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= fill_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      tag_q[wr_idx] <= wr_cotag;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      assign look_match[g]  = valid_q[g] && (vpn_q[g] == look_vpn);
      assign fill_match[g]  = valid_q[g] && (vpn_q[g] == fill_vpn);
      assign snoop_match[g] = valid_q[g] && (tag_q[g] == snoop_spa);

      // a write wins over a same-cycle snoop clear
      always_ff @(posedge clk) begin
        if (rst)
          valid_q[g] <= 1'b0;
        else if (wr_en && (wr_idx == IW'(g)))
          valid_q[g] <= 1'b1;
        else if (inv_en && snoop_match[g])
          valid_q[g] <= 1'b0;
      end

      assert_snoop_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (inv_en && snoop_match[g] && !(wr_en && wr_idx == IW'(g))) |=> !valid_q[g]);

      assert_snoop_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_q[g] && !snoop_match[g] && inv_en) |=> valid_q[g]);
    end
  endgenerate

  always_comb begin
    look_pfn_any = '0;
    for (int i = 0; i < N; i++)
      if (look_match[i]) look_pfn_any = look_pfn_any | pfn_q[i];
  end

  assert_no_dup_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_match));

  assert_fill_valid_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/cotag_tlb_lru.sv
module cotag_tlb_lru #(
  parameter int N   = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);

  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [N];
  logic [IW-1:0] touched_age;
  logic [N-1:0]  oldest_vec;

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)
          age_q[i] <= '0;
        else if (age_q[i] < touched_age)
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      oldest_vec[i] = (age_q[i] == IW'(N - 1));
      if (oldest_vec[i]) victim_idx = IW'(i);
    end
  end

  assert_single_victim_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);

endmodule

// File: rtl/cotag_tlb_snoop.sv
module cotag_tlb_snoop (
  input  logic clk,
  input  logic rst,
  input  logic snoop_valid,
  output logic snoop_ready,
  output logic snoop_ack,
  output logic accept
);

  logic ack_q;

  assign snoop_ready = !ack_q;
  assign accept      = snoop_valid && snoop_ready;
  assign snoop_ack   = ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= accept;
  end

  assert_ack_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_ready) |=> snoop_ack);

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
    snoop_ack |=> !snoop_ack);

  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(snoop_ack) |-> $past(snoop_valid));

endmodule

// File: rtl/cotag_tlb.sv
module cotag_tlb
  import cotag_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int SPA_W   = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             look_valid,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic             look_miss,
  output logic [PFN_W-1:0] look_pfn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [SPA_W-1:0] fill_cotag,
  input  logic             snoop_valid,
  input  logic [SPA_W-1:0] snoop_spa,
  output logic             snoop_ready,
  output logic             snoop_ack
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_vec, look_match, fill_match, snoop_match, look_eff;
  logic [PFN_W-1:0]   pfn_any;
  logic               snoop_accept;
  logic [IW-1:0]      free_idx, reuse_idx, hit_idx, victim_idx, slot_idx, touch_idx;
  logic               any_free, look_now_hit, touch_en;
  slot_src_e          slot_src;

  cotag_tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .SPA_W(SPA_W)) u_cam (
    .clk          (clk),
    .rst          (rst),
    .look_vpn     (look_vpn),
    .fill_vpn     (fill_vpn),
    .snoop_spa    (snoop_spa),
    .wr_en        (fill_valid),
    .wr_idx       (slot_idx),
    .wr_pfn       (fill_pfn),
    .wr_cotag     (fill_cotag),
    .inv_en       (snoop_accept),
    .valid_vec    (valid_vec),
    .look_match   (look_match),
    .fill_match   (fill_match),
    .snoop_match  (snoop_match),
    .look_pfn_any (pfn_any)
  );

  cotag_tlb_lru #(.N(ENTRIES)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  cotag_tlb_snoop u_snoop (
    .clk         (clk),
    .rst         (rst),
    .snoop_valid (snoop_valid),
    .snoop_ready (snoop_ready),
    .snoop_ack   (snoop_ack),
    .accept      (snoop_accept)
  );

  // a lookup loses an entry that a same-cycle snoop removes
  assign look_eff     = look_match & ~(snoop_match & {ENTRIES{snoop_accept}});
  assign look_now_hit = look_valid && (|look_eff);
  assign any_free     = ~&valid_vec;

  always_comb begin
    free_idx  = '0;
    reuse_idx = '0;
    hit_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx  = IW'(i);
      if (fill_match[i]) reuse_idx = IW'(i);
      if (look_eff[i])   hit_idx   = IW'(i);
    end
  end

  always_comb begin
    if (|fill_match)   slot_src = SLOT_REUSE;
    else if (any_free) slot_src = SLOT_FREE;
    else               slot_src = SLOT_EVICT;
    case (slot_src)
      SLOT_REUSE: slot_idx = reuse_idx;
      SLOT_FREE:  slot_idx = free_idx;
      default:    slot_idx = victim_idx;
    endcase
  end

  // a fill takes the single recency update when both occur
  assign touch_en  = fill_valid || look_now_hit;
  assign touch_idx = fill_valid ? slot_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      look_hit  <= 1'b0;
      look_miss <= 1'b0;
      look_pfn  <= '0;
    end else begin
      look_hit  <= look_now_hit;
      look_miss <= look_valid && !(|look_eff);
      look_pfn  <= look_now_hit ? pfn_any : '0;
    end
  end

  assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(look_hit && look_miss));

  assert_answer_R2: assert property (@(posedge clk) disable iff (rst)
    look_valid |=> (look_hit || look_miss));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !look_valid |=> !(look_hit || look_miss));

  assert_snoop_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (look_valid && snoop_accept && ((look_match & snoop_match) != '0)) |=> look_miss);

endmodule

// File: tb/cotag_tlb_test.sv
module cotag_tlb_test;

  localparam int N  = 8;
  localparam int VW = 12;
  localparam int PW = 12;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic look_valid = 1'b0, fill_valid = 1'b0, snoop_valid = 1'b0;
  logic [VW-1:0] look_vpn = '0, fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [SW-1:0] fill_cotag = '0, snoop_spa = '0;
  logic look_hit, look_miss, snoop_ready, snoop_ack;
  logic [PW-1:0] look_pfn;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  bit           exp_hit_q [$];
  logic [PW-1:0] exp_pfn_q [$];
  string        exp_req_q [$];

  always #4 clk = ~clk;

  cotag_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .SPA_W(SW)) uut (
    .clk(clk), .rst(rst),
    .look_valid(look_valid), .look_vpn(look_vpn),
    .look_hit(look_hit), .look_miss(look_miss), .look_pfn(look_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_cotag(fill_cotag),
    .snoop_valid(snoop_valid), .snoop_spa(snoop_spa),
    .snoop_ready(snoop_ready), .snoop_ack(snoop_ack)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops one expected item for every answer
  always @(negedge clk) begin
    if (!rst && (look_hit || look_miss)) begin
      if (exp_hit_q.size() == 0) begin
        check(0, "R2 unexpected answer", {look_hit, look_miss}, 0);
      end else begin
        automatic bit    eh = exp_hit_q.pop_front();
        automatic logic [PW-1:0] ep = exp_pfn_q.pop_front();
        automatic string er = exp_req_q.pop_front();
        check(look_hit == eh && look_miss == !eh, er, {look_hit, look_miss}, {eh, !eh});
        if (eh) check(look_pfn == ep, er, look_pfn, ep);
      end
    end
  end

  task automatic expect_look(input logic [VW-1:0] v, input bit h, input logic [PW-1:0] p,
                             input string rq);
    look_valid = 1'b1;
    look_vpn   = v;
    exp_hit_q.push_back(h);
    exp_pfn_q.push_back(p);
    exp_req_q.push_back(rq);
  endtask

  task automatic look(input logic [VW-1:0] v, input bit h, input logic [PW-1:0] p,
                      input string rq);
    expect_look(v, h, p, rq);
    @(negedge clk);
    look_valid = 1'b0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [SW-1:0] t);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_cotag = t;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic snoop(input logic [SW-1:0] a, input string rq);
    check(snoop_ready == 1'b1, "R8 ready before snoop", snoop_ready, 1);
    snoop_valid = 1'b1; snoop_spa = a;
    @(negedge clk);
    snoop_valid = 1'b0;
    check(snoop_ack == 1'b1 && snoop_ready == 1'b0, rq, {snoop_ack, snoop_ready}, 2'b10);
    @(negedge clk);
    check(snoop_ack == 1'b0 && snoop_ready == 1'b1, "R8 ack one cycle", {snoop_ack, snoop_ready}, 2'b01);
  endtask

  function automatic logic [PW-1:0] pf(input int i); return PW'(12'h100 + i); endfunction
  function automatic logic [SW-1:0] tg(input int i); return SW'(16'h1000 + i / 2); endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(snoop_ready && !snoop_ack && !look_hit && !look_miss, "R1 reset outputs",
          {snoop_ready, snoop_ack, look_hit, look_miss}, 4'b1000);
    look(12'h005, 0, 0, "R1 miss after reset");

    // R3: same-cycle fill and lookup sees old contents
    fill_valid = 1'b1; fill_vpn = 12'h010; fill_pfn = pf(0); fill_cotag = tg(0);
    expect_look(12'h010, 0, 0, "R3 lookup during fill");
    @(negedge clk);
    fill_valid = 1'b0; look_valid = 1'b0;
    look(12'h010, 1, pf(0), "R3 hit after fill");

    for (int i = 1; i < N; i++) fill(VW'(12'h010 + i), pf(i), tg(i));
    for (int i = 0; i < N; i++) look(VW'(12'h010 + i), 1, pf(i), "R3 all entries hit");

    // R4: overwrite vpn 13 with a new frame and co-tag
    fill(12'h013, 12'h2AA, 16'h2000);
    look(12'h013, 1, 12'h2AA, "R4 overwrite frame");
    // R6: old co-tag 1001 now only on vpn 12
    snoop(16'h1001, "R6 snoop acked");
    look(12'h012, 0, 0, "R6 matching entry dropped");
    look(12'h013, 1, 12'h2AA, "R4 co-tag replaced");
    snoop(16'h2000, "R6 snoop acked");
    look(12'h013, 0, 0, "R4 new co-tag matched");
    // R7: no-match snoop
    snoop(16'h3FFF, "R7 no-match acked");
    for (int i = 0; i < N; i++)
      if (i != 2 && i != 3) look(VW'(12'h010 + i), 1, pf(i), "R7 contents unchanged");

    // R5: two free slots used before any eviction
    fill(12'h020, 12'h220, 16'h3000);
    fill(12'h021, 12'h221, 16'h3001);
    look(12'h010, 1, pf(0), "R5 no eviction");
    look(12'h011, 1, pf(1), "R5 no eviction");
    for (int i = 4; i < N; i++) look(VW'(12'h010 + i), 1, pf(i), "R5 no eviction");
    look(12'h020, 1, 12'h220, "R5 free slot used");
    // LRU is now vpn 21
    fill(12'h030, 12'h330, 16'h3002);
    look(12'h021, 0, 0, "R5 LRU evicted");
    look(12'h030, 1, 12'h330, "R5 new entry");
    // LRU is now vpn 10
    fill(12'h031, 12'h331, 16'h3003);
    look(12'h010, 0, 0, "R5 second LRU evicted");
    look(12'h031, 1, 12'h331, "R5 second new entry");
    look(12'h011, 1, pf(1), "R5 survivor");

    // R9: lookup and matching snoop in one cycle
    snoop_valid = 1'b1; snoop_spa = 16'h1000;
    expect_look(12'h011, 0, 0, "R9 snooped lookup misses");
    @(negedge clk);
    snoop_valid = 1'b0; look_valid = 1'b0;
    check(snoop_ack == 1'b1, "R9 snoop served", snoop_ack, 1);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_spa = 16'h3FFE;
    expect_look(12'h014, 1, pf(4), "R9 unrelated lookup hits");
    @(negedge clk);
    snoop_valid = 1'b0; look_valid = 1'b0;
    @(negedge clk);

    // R10: fill and snoop in one cycle, fill's co-tag matches
    snoop_valid = 1'b1; snoop_spa = 16'h1002;
    fill_valid = 1'b1; fill_vpn = 12'h040; fill_pfn = 12'h440; fill_cotag = 16'h1002;
    @(negedge clk);
    snoop_valid = 1'b0; fill_valid = 1'b0;
    @(negedge clk);
    look(12'h040, 1, 12'h440, "R10 fill survives snoop");
    look(12'h014, 0, 0, "R10 snoop still applied");
    look(12'h015, 0, 0, "R10 snoop still applied");

    // R8: snoop held high is accepted every second cycle
    snoop_valid = 1'b1; snoop_spa = 16'h3FFD;
    @(negedge clk);
    check(snoop_ack && !snoop_ready, "R8 first accept", {snoop_ack, snoop_ready}, 2'b10);
    @(negedge clk);
    check(!snoop_ack && snoop_ready, "R8 blocked cycle", {snoop_ack, snoop_ready}, 2'b01);
    @(negedge clk);
    check(snoop_ack && !snoop_ready, "R8 second accept", {snoop_ack, snoop_ready}, 2'b10);
    snoop_valid = 1'b0;
    @(negedge clk);
    check(!snoop_ack, "R8 pulse ends", snoop_ack, 0);

    repeat (3) @(negedge clk);
    check(exp_hit_q.size() == 0, "R2 all lookups answered", exp_hit_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule